// File: doc/BRIEF.md
# Battery Charge Mode Controller

This block is the digital decision logic beside a linear battery charger. Each time an ADC delivers a sample, it receives the battery voltage code and the code of the voltage across the current-sense resistor. On that sample it selects the current-limit setpoint, decides between constant-current and constant-voltage regulation, and keeps an end-of-charge flag. It also drives the gate control of the external pass transistor. The analog regulation loop, the sense resistor and the pass device lie outside the block.

Two operating modes are chosen by a host-driven mode input. In automatic mode (mode low, for lithium cells) the controller runs the charge sequence by itself. In host mode (mode high, for pulse-charged nickel cells) the gate control follows a host gate input directly. An overvoltage cut-off with hysteresis guards host mode. Every threshold is a parameter in millivolts and is converted to ADC codes at elaboration. With the defaults, codes are `mv*1023/6000` for the battery (10-bit, 6000 mV full scale) and `mv*1023/200` for the sense input (200 mV full scale), truncated.

Top module: `chg_mode_ctrl`

## Requirements
- R1: During and after reset, before any sample: `gate_off`=1 while no charger is present, `eoc`=0, `cv_mode`=0 and `ilim_code` holds the trickle setpoint (20 mV, code 102).
- R2: On each valid sample with a charger present, `ilim_code` becomes the trickle code (20 mV → 102) if `uv_flag` is 1, or the full code (160 mV → 818) if it is 0. The new value is visible one clock after the sampling edge.
- R3: On a valid sample, `cv_mode` becomes 1 when `mode_host`=0 and the battery code is at least the 4200 mV code (716); otherwise it becomes 0.
- R4: In automatic mode, a valid sample with a battery code above the 4000 mV code (682) and a sense code at or below the 14 mV code (71) sets `eoc`.
- R5: In automatic mode, a valid sample with a battery code below the 3960 mV code (675) clears `eoc`. Between the two thresholds, and in host mode, `eoc` holds its value.
- R6: In host mode with a charger present, `gate_off` equals `host_gate` in the same cycle, unless the overvoltage lock is set. Mode high with gate high therefore stops charging.
- R7: In host mode, a valid sample with a battery code above the 5500 mV code (937) sets an overvoltage lock that forces `gate_off`=1. The lock clears only on a sample below the 5300 mV code (903). It also clears on any valid sample taken in automatic mode.
- R8: In automatic mode with a charger present, `gate_off` is 0.
- R9: With `chg_present`=0, `gate_off` is 1 at once. At the next clock `eoc`, `cv_mode` and the overvoltage lock clear and `ilim_code` returns to the trickle code.
- R10: A clock edge without `smp_valid` leaves `ilim_code`, `cv_mode`, `eoc` and the lock unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe; decisions update only when high |
| vbat_code | input | 10 | Battery voltage ADC code |
| vsns_code | input | 10 | Current-sense voltage ADC code |
| chg_present | input | 1 | Charger adapter detected |
| uv_flag | input | 1 | Battery below undervoltage threshold |
| mode_host | input | 1 | 0 = automatic (lithium), 1 = host-driven gate |
| host_gate | input | 1 | Host gate request, 1 = pass device off |
| ilim_code | output | 10 | Current-limit setpoint in sense-ADC codes |
| cv_mode | output | 1 | Constant-voltage regulation selected |
| gate_off | output | 1 | Gate control, 1 = pass device off |
| eoc | output | 1 | End-of-charge flag |

## Verification
In automatic mode the battery code is swept one code at a time, upward and then downward. This is done once with a sense code below the end-of-charge limit and once above it. The sweeps separate the constant-voltage edge and the end-of-charge set edge, and the down-sweep exposes the band where the flag must hold before it clears. In host mode the battery code is swept through the overvoltage band in both directions with the host gate both low and high. This tells the set point apart from the release point and shows the gate pass-through. The undervoltage flag is toggled against the setpoint output. Samples with the strobe low and removal of the charger are interleaved to show that state holds or clears as required.

// File: rtl/chg_pkg.sv
// Package: shared conversion helper for the charge mode controller.
// Assumes thresholds are non-negative millivolt values below full scale.
package chg_pkg;
    // Convert a millivolt value to an ADC code of the given width, truncating.
    function automatic int mv2code(input int mv, input int fs_mv, input int w);
        return (mv * ((1 << w) - 1)) / fs_mv;
    endfunction
endpackage

// File: rtl/chg_setpoint.sv
// Module: registers the current-limit setpoint and the CC/CV choice.
// Assumes the compare flag is computed from the current sample.
module chg_setpoint #(
    parameter int W = 10,
    parameter logic [W-1:0] LO_CODE = '0,
    parameter logic [W-1:0] HI_CODE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         upd,
    input  logic         uv,
    input  logic         auto_mode,
    input  logic         at_cv,
    output logic [W-1:0] ilim,
    output logic         cv
);
    // Update setpoint and regulation mode on valid samples; clear on charger loss.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ilim <= LO_CODE;
            cv   <= 1'b0;
        end else if (upd) begin
            ilim <= uv ? LO_CODE : HI_CODE;
            cv   <= auto_mode && at_cv;
        end
    end
endmodule

// File: rtl/chg_eoc_latch.sv
// Module: end-of-charge flag with separate set and clear thresholds.
// Assumes set and clear conditions are mutually exclusive.
module chg_eoc_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic upd,
    input  logic en,
    input  logic set_c,
    input  logic rel_c,
    output logic eoc
);
    // Set or release the flag only on valid samples in automatic mode.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)            eoc <= 1'b0;
        else if (upd && en && rel_c)  eoc <= 1'b0;
        else if (upd && en && set_c)  eoc <= 1'b1;
    end
endmodule

// File: rtl/chg_ov_guard.sv
// Module: overvoltage lock with hysteresis, active only in host mode.
// Assumes the release threshold lies below the trip threshold.
module chg_ov_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic upd,
    input  logic en,
    input  logic trip,
    input  logic rel,
    output logic lock
);
    // Trip above the upper level, release below the lower level.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  lock <= 1'b0;
        else if (upd) begin
            if (!en)        lock <= 1'b0;
            else if (trip)  lock <= 1'b1;
            else if (rel)   lock <= 1'b0;
        end
    end
endmodule

// File: rtl/chg_mode_ctrl.sv
// Module: top of the charge mode controller. Converts millivolt thresholds
// to codes, compares each sample, and combines registered state with the
// live mode and gate inputs to drive the pass-device gate control.
// Assumes samples are already synchronous to clk.
module chg_mode_ctrl #(
    parameter int W          = 10,
    parameter int VBAT_FS_MV = 6000,
    parameter int VSNS_FS_MV = 200,
    parameter int TRICKLE_MV = 20,
    parameter int FULL_MV    = 160,
    parameter int CV_MV      = 4200,
    parameter int EOC_V_MV   = 4000,
    parameter int EOC_I_MV   = 14,
    parameter int EOC_RST_MV = 3960,
    parameter int OV_MV      = 5500,
    parameter int OV_HYS_MV  = 200
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid,
    input  logic [W-1:0] vbat_code,
    input  logic [W-1:0] vsns_code,
    input  logic         chg_present,
    input  logic         uv_flag,
    input  logic         mode_host,
    input  logic         host_gate,
    output logic [W-1:0] ilim_code,
    output logic         cv_mode,
    output logic         gate_off,
    output logic         eoc
);
    import chg_pkg::*;

    localparam logic [W-1:0] LO_C   = W'(mv2code(TRICKLE_MV, VSNS_FS_MV, W));
    localparam logic [W-1:0] HI_C   = W'(mv2code(FULL_MV, VSNS_FS_MV, W));
    localparam logic [W-1:0] CV_C   = W'(mv2code(CV_MV, VBAT_FS_MV, W));
    localparam logic [W-1:0] EV_C   = W'(mv2code(EOC_V_MV, VBAT_FS_MV, W));
    localparam logic [W-1:0] EI_C   = W'(mv2code(EOC_I_MV, VSNS_FS_MV, W));
    localparam logic [W-1:0] ER_C   = W'(mv2code(EOC_RST_MV, VBAT_FS_MV, W));
    localparam logic [W-1:0] OV_C   = W'(mv2code(OV_MV, VBAT_FS_MV, W));
    localparam logic [W-1:0] OR_C   = W'(mv2code(OV_MV - OV_HYS_MV, VBAT_FS_MV, W));

    logic upd, clr, at_cv, eoc_set, eoc_rel, ov_trip, ov_rel, ov_lock;

    // Threshold comparisons on the current sample.
    always_comb begin
        upd     = smp_valid && chg_present;
        clr     = !chg_present;
        at_cv   = vbat_code >= CV_C;
        eoc_set = (vbat_code > EV_C) && (vsns_code <= EI_C);
        eoc_rel = vbat_code < ER_C;
        ov_trip = vbat_code > OV_C;
        ov_rel  = vbat_code < OR_C;
    end

    chg_setpoint #(.W(W), .LO_CODE(LO_C), .HI_CODE(HI_C)) u_set (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .uv(uv_flag),
        .auto_mode(!mode_host), .at_cv(at_cv), .ilim(ilim_code), .cv(cv_mode)
    );

    chg_eoc_latch u_eoc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .en(!mode_host),
        .set_c(eoc_set), .rel_c(eoc_rel), .eoc(eoc)
    );

    chg_ov_guard u_ov (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .en(mode_host),
        .trip(ov_trip), .rel(ov_rel), .lock(ov_lock)
    );

    // Gate control: off without charger, host-driven or locked in host mode.
    always_comb gate_off = !chg_present || (mode_host && (host_gate || ov_lock));
endmodule

// File: rtl/chg_mode_ctrl_chk.sv
// Module: property checker for the charge mode controller, bound to the top.
module chg_mode_ctrl_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         smp_valid,
    input logic         chg_present,
    input logic         mode_host,
    input logic         host_gate,
    input logic [W-1:0] ilim_code,
    input logic         cv_mode,
    input logic         gate_off,
    input logic         eoc
);
    a_r9_absent_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_present |-> gate_off);
    a_r9_absent_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_present |=> (!eoc && !cv_mode));
    a_r6_host_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_present && mode_host && host_gate) |-> gate_off);
    a_r8_auto_gate_on: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_present && !mode_host) |-> !gate_off);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && chg_present) |=> ($stable(ilim_code) && $stable(cv_mode) && $stable(eoc)));
    a_r4_eoc_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !eoc) |=> !eoc);
endmodule

bind chg_mode_ctrl chg_mode_ctrl_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .chg_present(chg_present),
    .mode_host(mode_host), .host_gate(host_gate), .ilim_code(ilim_code),
    .cv_mode(cv_mode), .gate_off(gate_off), .eoc(eoc)
);

// File: tb/chg_mode_ctrl_test.sv
// Bench: sweeps battery codes across every threshold in both modes and
// compares outputs with an arithmetic model kept in the bench.
module chg_mode_ctrl_test;
    localparam int W = 10;
    localparam int LO = (20 * 1023) / 200;
    localparam int HI = (160 * 1023) / 200;
    localparam int CV = (4200 * 1023) / 6000;
    localparam int EV = (4000 * 1023) / 6000;
    localparam int EI = (14 * 1023) / 200;
    localparam int ER = (3960 * 1023) / 6000;
    localparam int OV = (5500 * 1023) / 6000;
    localparam int OR = (5300 * 1023) / 6000;

    logic clk = 0, rst_n = 0, smp_valid = 0, chg_present = 0, uv_flag = 1;
    logic mode_host = 0, host_gate = 0;
    logic [W-1:0] vbat_code = '0, vsns_code = '0, ilim_code;
    logic cv_mode, gate_off, eoc;
    int errors = 0, checks = 0;

    int m_ilim = LO;
    bit m_cv = 0, m_eoc = 0, m_ov = 0;

    always #10 clk = ~clk;

    chg_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .vbat_code(vbat_code),
        .vsns_code(vsns_code), .chg_present(chg_present), .uv_flag(uv_flag),
        .mode_host(mode_host), .host_gate(host_gate), .ilim_code(ilim_code),
        .cv_mode(cv_mode), .gate_off(gate_off), .eoc(eoc)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, update the model, then compare.
    task automatic step(input int vb, input int vs, input bit uv, input bit md,
                        input bit hg, input bit pr, input bit vl);
        @(negedge clk);
        vbat_code = W'(vb); vsns_code = W'(vs); uv_flag = uv;
        mode_host = md; host_gate = hg; chg_present = pr; smp_valid = vl;
        @(posedge clk);
        if (!pr) begin
            m_ilim = LO; m_cv = 0; m_eoc = 0; m_ov = 0;
        end else if (vl) begin
            m_ilim = uv ? LO : HI;
            m_cv = !md && vb >= CV;
            if (!md) begin
                if (vb < ER) m_eoc = 0;
                else if (vb > EV && vs <= EI) m_eoc = 1;
                m_ov = 0;
            end else begin
                if (vb > OV) m_ov = 1;
                else if (vb < OR) m_ov = 0;
            end
        end
        @(negedge clk);
        chk("R2 ilim", int'(ilim_code), m_ilim);
        chk("R3 cv", int'(cv_mode), int'(m_cv));
        chk("R4/R5 eoc", int'(eoc), int'(m_eoc));
        chk("R6/R7/R8 gate", int'(gate_off), int'(!pr || (md && (hg || m_ov))));
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 gate", int'(gate_off), 1);
        chk("R1 eoc", int'(eoc), 0);
        chk("R1 cv", int'(cv_mode), 0);
        chk("R1 ilim", int'(ilim_code), LO);
        rst_n = 1;
        // R2: undervoltage flag toggling
        step(600, 0, 1, 0, 0, 1, 1);
        step(600, 0, 0, 0, 0, 1, 1);
        step(600, 0, 1, 0, 0, 1, 1);
        step(600, 0, 0, 0, 0, 1, 1);
        // R3/R4/R5: automatic sweeps, low then high sense
        for (int v = 640; v <= 740; v++) step(v, 40, 0, 0, 0, 1, 1);
        for (int v = 740; v >= 640; v--) step(v, 40, 0, 0, 0, 1, 1);
        for (int v = 640; v <= 740; v++) step(v, EI + 1, 0, 0, 0, 1, 1);
        for (int s = 60; s <= 80; s++) step(700, s, 0, 0, 0, 1, 1);
        // R5: hold in band then clear
        step(678, 90, 0, 0, 0, 1, 1);
        chk("R5 hold in band", int'(eoc), 1);
        step(674, 90, 0, 0, 0, 1, 1);
        chk("R5 clear", int'(eoc), 0);
        // R10: no strobe keeps state
        step(700, 10, 0, 0, 0, 1, 1);
        step(600, 10, 1, 0, 0, 1, 0);
        chk("R10 eoc held", int'(eoc), 1);
        chk("R10 ilim held", int'(ilim_code), HI);
        // R5: host mode holds eoc
        step(600, 10, 0, 1, 0, 1, 1);
        chk("R5 host hold", int'(eoc), 1);
        // R6/R7: host sweeps with gate low and high
        for (int g = 0; g < 2; g++) begin
            for (int v = 880; v <= 1000; v++) step(v, 0, 0, 1, g[0], 1, 1);
            for (int v = 1000; v >= 880; v--) step(v, 0, 0, 1, g[0], 1, 1);
        end
        step(950, 0, 0, 1, 0, 1, 1);
        chk("R7 lock", int'(gate_off), 1);
        step(910, 0, 0, 1, 0, 1, 0);
        step(910, 0, 0, 1, 0, 1, 1);
        chk("R7 hysteresis hold", int'(gate_off), 1);
        // R9: charger removal clears everything
        step(910, 0, 0, 1, 0, 0, 1);
        chk("R9 gate", int'(gate_off), 1);
        step(910, 0, 0, 1, 0, 1, 0);
        chk("R9 lock cleared", int'(gate_off), 0);
        step(700, 10, 0, 0, 0, 1, 1);
        step(700, 10, 0, 0, 0, 0, 0);
        chk("R9 eoc cleared", int'(eoc), 0);
        chk("R9 ilim trickle", int'(ilim_code), LO);
        // R8: automatic mode keeps gate on with high battery
        step(1000, 0, 0, 0, 1, 1, 1);
        chk("R8 gate on", int'(gate_off), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule